// File: doc/BRIEF.md
# Supervisor-Gated Board Control Register Bank

This block holds eight byte-wide control registers for a processor accelerator card. It sits on a simple byte bus driven by the CPU. An access takes effect only when the CPU is in supervisor mode and the address matches a fixed pattern under a mask. Three address bits pick one of the eight registers.

Reads return the stored byte, with a hard-wired board revision code placed over one bit of the lowest registers. One bit of a chosen register enables remapping of the boot ROM image. When a write flips that bit, the block updates a registered enable level and raises a one-cycle change pulse. Logic outside the block uses the pulse to copy the ROM image in, or to restore the original. The copy itself is not part of this block.

Top module: `board_ctrl_regs`

## Requirements
- R1: A synchronous active-high reset clears all eight registers to 0x00, drives `remap_en` to 0 and keeps `remap_pulse` at 0.
- R2: An access is valid only when `supervisor` is 1 and (`addr` AND 0xFF0F) equals 0x0C0C. Address bit 7 is outside the mask, so it does not affect the match.
- R3: On a valid write (`wr_en`=1), the register selected by `addr[6:4]` stores `wdata` at the clock edge.
- R4: A write that is not valid, either from user mode or from an address that does not match, changes no register and does not change `remap_en`.
- R5: `rdata` is 0 whenever `rd_en` is 0 or the access is not valid.
- R6: On a valid read, registers 0 to 3 return the stored byte with bit 2 replaced. Bit 2 reads as 1 for register 0 and as 0 for registers 1 to 3. Registers 4 to 7 return the stored byte unchanged.
- R7: A valid write to register 3 whose bit 0 differs from the stored bit 0 sets `remap_en` to the new bit 0 at that clock edge. In the same edge it raises `remap_pulse` for exactly one cycle.
- R8: A valid write to register 3 that leaves bit 0 unchanged produces no pulse. So does a write to any other register.
- R9: Read data is combinational: it follows `addr`, `rd_en` and `supervisor` within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | Byte address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| supervisor | input | 1 | CPU is in supervisor mode |
| rdata | output | 8 | Read data, 0 when the access is not a valid read |
| remap_en | output | 1 | Registered ROM remap enable level |
| remap_pulse | output | 1 | One-cycle pulse when the remap enable toggles |

## Verification
The hardest case to reach from the ports is a remap toggle that sits next to near-miss accesses. Examples are a register 3 write from user mode, a register 3 write that keeps bit 0 unchanged, and a toggle write right after a pulse cycle. Random addresses almost never hit the decode pattern, so half the random accesses are built on the matching pattern with a random index and a random bit 7. The supervisor flag is random on each access. Directed sequences then run set, hold, clear and a user-mode attempt on register 3, and check the pulse on the cycle after each write and on the cycle after that.

// File: rtl/bcr_pkg.sv
package bcr_pkg;

  typedef struct packed {
    logic wr;
    logic rd;
  } bcr_acc_t;

  typedef enum logic [1:0] {
    REMAP_HOLD = 2'd0,
    REMAP_SET  = 2'd1,
    REMAP_CLR  = 2'd2
  } remap_act_e;

endpackage

// File: rtl/bcr_addr_decode.sv
module bcr_addr_decode
  import bcr_pkg::*;
#(
  parameter int              ADDR_W     = 16,
  parameter int              IDX_LSB    = 4,
  parameter int              IDX_W      = 3,
  parameter logic [ADDR_W-1:0] MATCH_MASK = 16'hFF0F,
  parameter logic [ADDR_W-1:0] MATCH_VAL  = 16'h0C0C
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              supervisor,
  input  logic              wr_en,
  input  logic              rd_en,
  output bcr_acc_t          acc,
  output logic [IDX_W-1:0]  idx
);

  logic hit;

  always_comb begin
    hit    = supervisor && ((addr & MATCH_MASK) == MATCH_VAL);
    acc.wr = hit && wr_en;
    acc.rd = hit && rd_en;
    idx    = addr[IDX_LSB +: IDX_W];
  end

endmodule

// File: rtl/bcr_regfile.sv
module bcr_regfile #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rbyte
);

  localparam int NREGS = 1 << IDX_W;

  logic [DATA_W-1:0] regs [NREGS];

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) begin
        q <= '0;
      end else if (we && (widx == IDX_W'(i))) begin
        q <= wdata;
      end
    end
    assign regs[i] = q;
  end

  assign rbyte = regs[ridx];

endmodule

// File: rtl/bcr_remap_detect.sv
module bcr_remap_detect
  import bcr_pkg::*;
#(
  parameter int IDX_W     = 3,
  parameter int REMAP_IDX = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_hit,
  input  logic [IDX_W-1:0] idx,
  input  logic             new_bit,
  output logic             remap_en,
  output logic             remap_pulse
);

  remap_act_e act;
  logic       en_q;
  logic       pulse_q;

  always_comb begin
    act = REMAP_HOLD;
    if (wr_hit && (idx == IDX_W'(REMAP_IDX)) && (new_bit != en_q)) begin
      act = new_bit ? REMAP_SET : REMAP_CLR;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= (act != REMAP_HOLD);
      case (act)
        REMAP_SET: en_q <= 1'b1;
        REMAP_CLR: en_q <= 1'b0;
        default:   en_q <= en_q;
      endcase
    end
  end

  assign remap_en    = en_q;
  assign remap_pulse = pulse_q;

endmodule

// File: rtl/bcr_read_overlay.sv
module bcr_read_overlay #(
  parameter int              DATA_W   = 8,
  parameter int              IDX_W    = 3,
  parameter int              REV_REGS = 4,
  parameter int              REV_BIT  = 2,
  parameter logic [REV_REGS-1:0] REV_CODE = 4'b0001
) (
  input  logic              rd_hit,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] raw,
  output logic [DATA_W-1:0] rdata
);

  localparam int NREGS = 1 << IDX_W;

  logic [NREGS-1:0] force_en;
  logic [NREGS-1:0] force_val;

  for (genvar i = 0; i < NREGS; i++) begin : g_rev
    if (i < REV_REGS) begin : g_on
      assign force_en[i]  = 1'b1;
      assign force_val[i] = REV_CODE[i];
    end else begin : g_off
      assign force_en[i]  = 1'b0;
      assign force_val[i] = 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_hit) begin
      rdata = raw;
      if (force_en[idx]) begin
        rdata[REV_BIT] = force_val[idx];
      end
    end
  end

endmodule

// File: rtl/board_ctrl_regs.sv
module board_ctrl_regs
  import bcr_pkg::*;
#(
  parameter int              ADDR_W     = 16,
  parameter int              DATA_W     = 8,
  parameter int              IDX_LSB    = 4,
  parameter int              IDX_W      = 3,
  parameter logic [ADDR_W-1:0] MATCH_MASK = 16'hFF0F,
  parameter logic [ADDR_W-1:0] MATCH_VAL  = 16'h0C0C,
  parameter int              REMAP_IDX  = 3,
  parameter int              REMAP_BIT  = 0,
  parameter int              REV_REGS   = 4,
  parameter int              REV_BIT    = 2,
  parameter logic [REV_REGS-1:0] REV_CODE = 4'b0001
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic              supervisor,
  output logic [DATA_W-1:0] rdata,
  output logic              remap_en,
  output logic              remap_pulse
);

  bcr_acc_t          acc;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] raw;

  bcr_addr_decode #(
    .ADDR_W(ADDR_W), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W),
    .MATCH_MASK(MATCH_MASK), .MATCH_VAL(MATCH_VAL)
  ) u_dec (
    .addr(addr), .supervisor(supervisor), .wr_en(wr_en), .rd_en(rd_en),
    .acc(acc), .idx(idx)
  );

  bcr_regfile #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_rf (
    .clk(clk), .rst(rst), .we(acc.wr), .widx(idx), .wdata(wdata),
    .ridx(idx), .rbyte(raw)
  );

  bcr_remap_detect #(.IDX_W(IDX_W), .REMAP_IDX(REMAP_IDX)) u_remap (
    .clk(clk), .rst(rst), .wr_hit(acc.wr), .idx(idx),
    .new_bit(wdata[REMAP_BIT]),
    .remap_en(remap_en), .remap_pulse(remap_pulse)
  );

  bcr_read_overlay #(
    .DATA_W(DATA_W), .IDX_W(IDX_W), .REV_REGS(REV_REGS),
    .REV_BIT(REV_BIT), .REV_CODE(REV_CODE)
  ) u_ovl (
    .rd_hit(acc.rd), .idx(idx), .raw(raw), .rdata(rdata)
  );

endmodule

// File: rtl/bcr_checker.sv
module bcr_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              rd_en,
  input logic              supervisor,
  input logic [DATA_W-1:0] rdata,
  input logic              remap_en,
  input logic              remap_pulse
);

  logic valid_rd0;
  assign valid_rd0 = rd_en && supervisor && ((addr & 16'hFF0F) == 16'h0C0C)
                     && (addr[6:4] == 3'd0);

  AST_PULSE_MEANS_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    remap_pulse |-> (remap_en != $past(remap_en))); // R7

  AST_TOGGLE_MEANS_PULSE: assert property (@(posedge clk) disable iff (rst)
    (remap_en != $past(remap_en)) |-> remap_pulse); // R7

  AST_PULSE_NEEDS_SUPER_WRITE: assert property (@(posedge clk) disable iff (rst)
    remap_pulse |-> $past(wr_en && supervisor)); // R8

  AST_EN_HOLDS_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en && supervisor) |-> $stable(remap_en)); // R4

  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    !rd_en |-> (rdata == '0)); // R5

  AST_USER_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    !supervisor |-> (rdata == '0)); // R2

  AST_REV_BIT_REG0: assert property (@(posedge clk) disable iff (rst)
    valid_rd0 |-> rdata[2]); // R6

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!remap_pulse && !remap_en)); // R1

endmodule

bind board_ctrl_regs bcr_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .supervisor(supervisor), .rdata(rdata), .remap_en(remap_en),
  .remap_pulse(remap_pulse)
);

// File: tb/board_ctrl_regs_tb.sv
module board_ctrl_regs_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic        supervisor = 1'b0;
  logic [7:0]  rdata;
  logic        remap_en;
  logic        remap_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] m_reg [8];
  logic       m_en;

  always #4 clk = ~clk;

  board_ctrl_regs u_dut (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .supervisor(supervisor), .rdata(rdata),
    .remap_en(remap_en), .remap_pulse(remap_pulse)
  );

  function automatic bit is_valid(logic [15:0] a, logic s);
    return s && ((a & 16'hFF0F) == 16'h0C0C);
  endfunction

  function automatic logic [7:0] exp_read(logic [15:0] a, logic s, logic r);
    logic [7:0] v;
    int i;
    if (!r || !is_valid(a, s)) return 8'h00;
    i = int'(a[6:4]);
    v = m_reg[i];
    if (i == 0) v[2] = 1'b1;
    else if (i < 4) v[2] = 1'b0;
    return v;
  endfunction

  function automatic logic [15:0] reg_addr(int i, bit b7);
    return {8'h0C, b7, 3'(i), 4'hC};
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_write(logic [15:0] a, logic [7:0] d, logic s, string req);
    bit v;
    bit exp_p;
    v = is_valid(a, s);
    exp_p = v && (a[6:4] == 3'd3) && (d[0] != m_en);
    @(negedge clk);
    addr = a; wdata = d; supervisor = s; wr_en = 1'b1; rd_en = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
    if (v) begin
      m_reg[int'(a[6:4])] = d;
      if (a[6:4] == 3'd3) m_en = d[0];
    end
    check(req, "remap_pulse after write", int'(remap_pulse), int'(exp_p));
    check(req, "remap_en after write", int'(remap_en), int'(m_en));
  endtask

  task automatic do_read(logic [15:0] a, logic s, logic r, string req);
    @(negedge clk);
    addr = a; supervisor = s; rd_en = r; wr_en = 1'b0;
    #1;
    check(req, "rdata", int'(rdata), int'(exp_read(a, s, r)));
    check("R7", "pulse cleared", int'(remap_pulse), 0);
    rd_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1234_5A5A));
    for (int i = 0; i < 8; i++) m_reg[i] = 8'h00;
    m_en = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check("R1", "remap_en at reset", int'(remap_en), 0);
    check("R1", "remap_pulse at reset", int'(remap_pulse), 0);
    for (int i = 0; i < 8; i++) do_read(reg_addr(i, 1'b0), 1'b1, 1'b1, "R1");

    // R3 store, R9 same-cycle read
    do_write(reg_addr(5, 1'b0), 8'hA5, 1'b1, "R3");
    do_read(reg_addr(5, 1'b0), 1'b1, 1'b1, "R9");
    // R6 revision overlay
    do_write(reg_addr(0, 1'b0), 8'h00, 1'b1, "R6");
    do_read(reg_addr(0, 1'b0), 1'b1, 1'b1, "R6");
    do_write(reg_addr(1, 1'b0), 8'hFF, 1'b1, "R6");
    do_read(reg_addr(1, 1'b0), 1'b1, 1'b1, "R6");
    do_write(reg_addr(6, 1'b0), 8'h04, 1'b1, "R6");
    do_read(reg_addr(6, 1'b0), 1'b1, 1'b1, "R6");
    // R2 bit 7 outside mask
    do_write(reg_addr(4, 1'b1), 8'h3C, 1'b1, "R2");
    do_read(reg_addr(4, 1'b0), 1'b1, 1'b1, "R2");
    // R4 ignored writes
    do_write(reg_addr(5, 1'b0), 8'h11, 1'b0, "R4");
    do_read(reg_addr(5, 1'b0), 1'b1, 1'b1, "R4");
    do_write(16'h0C5D, 8'h22, 1'b1, "R4");
    do_read(reg_addr(5, 1'b0), 1'b1, 1'b1, "R4");
    // R5 zero reads
    do_read(reg_addr(5, 1'b0), 1'b0, 1'b1, "R5");
    do_read(reg_addr(5, 1'b0), 1'b1, 1'b0, "R5");
    // R7 / R8 remap toggling
    do_write(reg_addr(3, 1'b0), 8'h01, 1'b1, "R7");
    do_read(reg_addr(3, 1'b0), 1'b1, 1'b1, "R7");
    do_write(reg_addr(3, 1'b0), 8'h03, 1'b1, "R8");
    do_write(reg_addr(2, 1'b0), 8'h00, 1'b1, "R8");
    do_write(reg_addr(3, 1'b0), 8'h00, 1'b1, "R7");
    do_write(reg_addr(3, 1'b0), 8'h01, 1'b0, "R4");
    do_write(reg_addr(3, 1'b0), 8'h01, 1'b1, "R7");
    do_write(reg_addr(3, 1'b0), 8'h00, 1'b1, "R7");

    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [15:0] a;
      logic        s;
      if ($urandom_range(1, 0) == 1)
        a = reg_addr(int'($urandom_range(7, 0)), 1'($urandom_range(1, 0)));
      else
        a = 16'($urandom());
      s = ($urandom_range(3, 0) != 0);
      if ($urandom_range(1, 0) == 1)
        do_write(a, 8'($urandom()), s, "R3");
      else
        do_read(a, s, 1'($urandom_range(3, 0) != 0), "R6");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule